// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter with Frame-Count Halt

This block turns bytes queued by software into asynchronous serial frames on a single output line. Software writes bytes into a 64-entry queue through a small register write port. It also selects the frame shape, sets a low-water level for the queue, loads a frame-count limit and enables the interrupt sources. A serialiser then drains the queue one frame at a time. Frames follow each other with no idle gap for as long as bytes remain in the queue.

Bit timing comes entirely from the `baud_tick` enable. Each transmitted bit lasts from one tick to the next. The serialiser is a five-state machine:

- IDLE holds the line at 1 and goes to START on a tick when a byte may be loaded.
- START drives the 0 bit and goes to DATA on a tick.
- DATA shifts the data bits LSB first. On the tick that ends the last data bit it goes to PARITY if parity is on, otherwise to STOP.
- PARITY goes to STOP on a tick.
- STOP drives 1 for one or two bit times. On the tick that ends the final stop bit it goes straight back to START if a byte may be loaded, otherwise to IDLE.

An optional halt counts completed frames. When the count reaches a programmed value, the serialiser stops loading and raises its own flag. This flag shares the single interrupt output with the queue-low flag.

Register addresses on `reg_addr` are as follows:

- 0 pushes `reg_wdata` into the queue.
- 1 writes the control byte: bit0 selects 8 data bits (0 selects 7), bit1 enables parity, bit2 selects odd parity (0 selects even), bit3 selects two stop bits, bit4 enables the low interrupt, bit5 enables the halt interrupt, bit6 enables the frame-count halt, and bit7 set empties the queue (a pulse that is not stored).
- 2 sets the low-water level from bits 5:0.
- 3 sets the frame-count limit.
- 4 clears status flags: writing 0 to a bit clears that flag and writing 1 leaves it alone. The bits are bit0 low, bit1 end, bit2 halt, bit3 overflow.

After reset the control byte is 0x01, and the low-water level and frame-count limit are both 0.

Top module: `fifo_uart_tx`

## Requirements
- R1: The queue holds up to 64 bytes in write order, and `fifo_level` always shows how many are held.
- R2: A push while the queue holds 64 bytes is dropped, and `flag_ovf` is set until software clears it through address 4 bit3.
- R3: Each frame is a 0 start bit, then 7 or 8 data bits LSB first, then an optional parity bit, then one or two 1 stop bits. The parity bit is the XOR of the data bits, inverted when odd parity is selected. Every bit lasts exactly one `baud_tick` period.
- R4: When a byte may be loaded at the tick that ends the final stop bit, the next start bit begins on that same tick.
- R5: When the queue is empty at the tick that ends the final stop bit, `flag_end` is set and `txd` stays at 1 until a new frame starts.
- R6: `flag_low` is set on every cycle after the queue level is at or below the low-water level. A clear written while the level stays there does not hold.
- R7: With the halt enabled, the frame whose completion makes the completed-frame count equal the limit sets `flag_stop`, and no further byte is loaded while the flag is set. Writing 0 to address 4 bit2 clears the flag and restarts the count at 0.
- R8: `irq` is high exactly when (`flag_low` and the low interrupt enable) or (`flag_stop` and the halt interrupt enable).
- R9: Emptying the queue through control bit7 drops all queued bytes but leaves the frame already being shifted out to finish unchanged.
- R10: After reset `txd` is 1, `fifo_level` is 0, `flag_end` and `flag_low` are 1, `flag_stop`, `flag_ovf` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| txd | output | 1 | Serial output line, 1 when idle |
| irq | output | 1 | Combined interrupt request |
| fifo_level | output | 7 | Bytes held in the queue |
| flag_low | output | 1 | Queue at or below low-water level |
| flag_end | output | 1 | Last frame ended with queue empty |
| flag_stop | output | 1 | Frame-count halt reached |
| flag_ovf | output | 1 | Push dropped on full queue |

## Verification
The hardest case to reach is the halt firing at the very tick where a back-to-back frame would otherwise start. The queue must still hold bytes at that moment, and the completed-frame count must be known exactly. The stimulus therefore first clears the halt flag, which restarts the count. It then sets the limit to 3 and queues six bytes at once, so the third frame ends with bytes still waiting. The halt is then cleared again so the remaining three frames go out and trip the limit a second time. Overflow is reached by a burst of pushes on consecutive cycles, which outruns the drain of the serialiser.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_PARITY,
        TX_STOP
    } tx_state_e;

    typedef struct packed {
        logic two_stop;
        logic par_odd;
        logic par_en;
        logic len8;
    } frame_cfg_t;

    localparam logic [2:0] ADDR_DATA = 3'd0;
    localparam logic [2:0] ADDR_CTRL = 3'd1;
    localparam logic [2:0] ADDR_TRIG = 3'd2;
    localparam logic [2:0] ADDR_LIMIT = 3'd3;
    localparam logic [2:0] ADDR_STAT = 3'd4;

endpackage

// File: rtl/tx_fifo.sv
module tx_fifo #(
    parameter int DEPTH = 64,
    parameter int W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         push,
    input  logic                         pop,
    input  logic [W-1:0]                 wdata,
    output logic [W-1:0]                 rdata,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             do_push;
    logic             do_pop;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + PTR_W'(1);
            if (do_pop)  rd_ptr <= rd_ptr + PTR_W'(1);
            unique case ({do_push, do_pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !clr) mem[wr_ptr] <= wdata;
    end

    // R1
    fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    // R1
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/tx_serializer.sv
module tx_serializer
    import uart_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       baud_tick,
    input  logic       may_load,
    input  logic [7:0] ld_data,
    input  frame_cfg_t cfg,
    output logic       pop,
    output logic       last_tick,
    output logic       txd
);
    tx_state_e  state;
    tx_state_e  state_n;
    logic [7:0] shreg;
    logic [2:0] bit_idx;
    logic       stop_second;
    logic       par_q;
    logic       len8_q;
    logic       par_en_q;
    logic       two_stop_q;
    logic       final_bit;
    logic [2:0] last_idx;
    logic [7:0] masked;

    assign last_idx  = len8_q ? 3'd7 : 3'd6;
    assign final_bit = (state == TX_STOP) && (!two_stop_q || stop_second);
    assign last_tick = baud_tick && final_bit;
    assign pop       = baud_tick && may_load && ((state == TX_IDLE) || final_bit);
    assign masked    = cfg.len8 ? ld_data : {1'b0, ld_data[6:0]};

    always_comb begin
        state_n = state;
        unique case (state)
            TX_IDLE:   if (baud_tick && may_load) state_n = TX_START;
            TX_START:  if (baud_tick) state_n = TX_DATA;
            TX_DATA:   if (baud_tick && bit_idx == last_idx)
                           state_n = par_en_q ? TX_PARITY : TX_STOP;
            TX_PARITY: if (baud_tick) state_n = TX_STOP;
            TX_STOP:   if (last_tick) state_n = may_load ? TX_START : TX_IDLE;
            default:   state_n = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state       <= TX_IDLE;
            shreg       <= '0;
            bit_idx     <= '0;
            stop_second <= 1'b0;
            par_q       <= 1'b0;
            len8_q      <= 1'b1;
            par_en_q    <= 1'b0;
            two_stop_q  <= 1'b0;
        end else begin
            state <= state_n;
            if (pop) begin
                shreg       <= ld_data;
                bit_idx     <= '0;
                stop_second <= 1'b0;
                par_q       <= cfg.par_odd ^ (^masked);
                len8_q      <= cfg.len8;
                par_en_q    <= cfg.par_en;
                two_stop_q  <= cfg.two_stop;
            end else if (baud_tick) begin
                if (state == TX_DATA) begin
                    shreg   <= {1'b0, shreg[7:1]};
                    bit_idx <= bit_idx + 3'd1;
                end
                if (state == TX_STOP && two_stop_q && !stop_second)
                    stop_second <= 1'b1;
            end
        end
    end

    always_comb begin
        txd = 1'b1;
        unique case (state)
            TX_IDLE:   txd = 1'b1;
            TX_START:  txd = 1'b0;
            TX_DATA:   txd = shreg[0];
            TX_PARITY: txd = par_q;
            TX_STOP:   txd = 1'b1;
            default:   txd = 1'b1;
        endcase
    end

    // R3
    bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != TX_IDLE && !baud_tick) |=> $stable(txd));

    // R4
    back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_tick && may_load) |=> (state == TX_START && !txd));

    // R5
    mark_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_tick && !may_load) |=> (state == TX_IDLE && txd));

endmodule

// File: rtl/fifo_uart_tx.sv
module fifo_uart_tx
    import uart_tx_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CNT_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       baud_tick,
    input  logic                       reg_wr,
    input  logic [2:0]                 reg_addr,
    input  logic [7:0]                 reg_wdata,
    output logic                       txd,
    output logic                       irq,
    output logic [$clog2(DEPTH+1)-1:0] fifo_level,
    output logic                       flag_low,
    output logic                       flag_end,
    output logic                       flag_stop,
    output logic                       flag_ovf
);
    localparam int LVL_W  = $clog2(DEPTH + 1);
    localparam int TRIG_W = $clog2(DEPTH);

    frame_cfg_t         cfg_r;
    logic               low_ie;
    logic               stop_ie;
    logic               stop_en;
    logic [TRIG_W-1:0]  trig_r;
    logic [CNT_W-1:0]   limit_r;
    logic [CNT_W-1:0]   sent_cnt;

    logic wr_push, wr_ctrl, wr_trig, wr_limit, wr_stat;
    logic fifo_clr, clr_low, clr_end, clr_stop, clr_ovf;
    logic full, empty, ser_pop, last_tick, stop_hit, halted, may_load;
    logic [7:0] rd_byte;

    assign wr_push  = reg_wr && (reg_addr == ADDR_DATA);
    assign wr_ctrl  = reg_wr && (reg_addr == ADDR_CTRL);
    assign wr_trig  = reg_wr && (reg_addr == ADDR_TRIG);
    assign wr_limit = reg_wr && (reg_addr == ADDR_LIMIT);
    assign wr_stat  = reg_wr && (reg_addr == ADDR_STAT);
    assign fifo_clr = wr_ctrl && reg_wdata[7];
    assign clr_low  = wr_stat && !reg_wdata[0];
    assign clr_end  = wr_stat && !reg_wdata[1];
    assign clr_stop = wr_stat && !reg_wdata[2];
    assign clr_ovf  = wr_stat && !reg_wdata[3];

    assign stop_hit = stop_en && last_tick && ((sent_cnt + CNT_W'(1)) == limit_r);
    assign halted   = stop_en && flag_stop;
    assign may_load = !empty && !halted && !stop_hit;

    tx_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (fifo_clr),
        .push  (wr_push),
        .pop   (ser_pop),
        .wdata (reg_wdata),
        .rdata (rd_byte),
        .count (fifo_level),
        .full  (full),
        .empty (empty)
    );

    tx_serializer u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .may_load  (may_load),
        .ld_data   (rd_byte),
        .cfg       (cfg_r),
        .pop       (ser_pop),
        .last_tick (last_tick),
        .txd       (txd)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_r   <= '{two_stop: 1'b0, par_odd: 1'b0, par_en: 1'b0, len8: 1'b1};
            low_ie  <= 1'b0;
            stop_ie <= 1'b0;
            stop_en <= 1'b0;
            trig_r  <= '0;
            limit_r <= '0;
        end else begin
            if (wr_ctrl) begin
                cfg_r.len8     <= reg_wdata[0];
                cfg_r.par_en   <= reg_wdata[1];
                cfg_r.par_odd  <= reg_wdata[2];
                cfg_r.two_stop <= reg_wdata[3];
                low_ie         <= reg_wdata[4];
                stop_ie        <= reg_wdata[5];
                stop_en        <= reg_wdata[6];
            end
            if (wr_trig)  trig_r  <= reg_wdata[TRIG_W-1:0];
            if (wr_limit) limit_r <= reg_wdata[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_low  <= 1'b1;
            flag_end  <= 1'b1;
            flag_stop <= 1'b0;
            flag_ovf  <= 1'b0;
            sent_cnt  <= '0;
        end else begin
            if (fifo_level <= LVL_W'(trig_r)) flag_low <= 1'b1;
            else if (clr_low)                 flag_low <= 1'b0;

            if (last_tick && empty) flag_end <= 1'b1;
            else if (clr_end)       flag_end <= 1'b0;

            if (stop_hit)      flag_stop <= 1'b1;
            else if (clr_stop) flag_stop <= 1'b0;

            if (clr_stop)       sent_cnt <= '0;
            else if (last_tick) sent_cnt <= sent_cnt + CNT_W'(1);

            if (wr_push && full) flag_ovf <= 1'b1;
            else if (clr_ovf)    flag_ovf <= 1'b0;
        end
    end

    assign irq = (flag_low && low_ie) || (flag_stop && stop_ie);

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_push && full && !ser_pop) |=> (fifo_level == LVL_W'(DEPTH) && flag_ovf));

    // R6
    low_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_level <= LVL_W'(trig_r)) |=> flag_low);

    // R7
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_en && flag_stop) |-> !ser_pop);

    // R7
    halt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_hit |=> flag_stop);

endmodule

// File: tb/fifo_uart_tx_bench.sv
`timescale 1ns/1ps
module fifo_uart_tx_bench;
    localparam int DIV = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic       txd, irq, flag_low, flag_end, flag_stop, flag_ovf;
    logic [6:0] fifo_level;

    int n_cmp = 0;
    int n_bad = 0;
    int tdiv  = 0;
    string cur_req = "R10";
    bit running = 0;

    // reference model state
    logic [7:0] mq[$];
    bit         mf[$];
    int  m_cnt, m_trig, m_limit;
    bit  m_len8, m_pen, m_podd, m_two, m_lie, m_sie, m_sen;
    bit  m_low, m_end, m_stop, m_ovf;

    always #4 clk = ~clk;

    fifo_uart_tx u_fifo_uart_tx (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .txd(txd), .irq(irq), .fifo_level(fifo_level),
        .flag_low(flag_low), .flag_end(flag_end),
        .flag_stop(flag_stop), .flag_ovf(flag_ovf)
    );

    always @(negedge clk) begin
        if (!rst_n) begin
            tdiv = 0;
            baud_tick = 1'b0;
        end else begin
            baud_tick = (tdiv == DIV - 1);
            tdiv = (tdiv + 1) % DIV;
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete(); mf.delete();
            m_cnt = 0; m_trig = 0; m_limit = 0;
            m_len8 = 1; m_pen = 0; m_podd = 0; m_two = 0;
            m_lie = 0; m_sie = 0; m_sen = 0;
            m_low = 1; m_end = 1; m_stop = 0; m_ovf = 0;
        end else begin
            int  old_size;
            bit  last, hit, push_ev, stat_ev;
            old_size = mq.size();
            last = 0; hit = 0;
            push_ev = reg_wr && reg_addr == 3'd0;
            stat_ev = reg_wr && reg_addr == 3'd4;
            if (baud_tick) begin
                if (mf.size() > 0) begin
                    if (mf.size() == 1) last = 1;
                    void'(mf.pop_front());
                end
                if (mf.size() == 0) begin
                    hit = last && m_sen && (((m_cnt + 1) % 256) == m_limit);
                    if (old_size > 0 && !(m_sen && m_stop) && !hit) begin
                        logic [7:0] b;
                        int nb, ones;
                        b = mq.pop_front();
                        nb = m_len8 ? 8 : 7;
                        ones = 0;
                        mf.push_back(1'b0);
                        for (int i = 0; i < nb; i++) begin
                            mf.push_back(b[i]);
                            ones += b[i];
                        end
                        if (m_pen) mf.push_back(((ones % 2) == 1) ^ m_podd);
                        mf.push_back(1'b1);
                        if (m_two) mf.push_back(1'b1);
                    end
                end
            end
            if (old_size <= m_trig) m_low = 1;
            else if (stat_ev && !reg_wdata[0]) m_low = 0;
            if (last && old_size == 0) m_end = 1;
            else if (stat_ev && !reg_wdata[1]) m_end = 0;
            if (hit) m_stop = 1;
            else if (stat_ev && !reg_wdata[2]) m_stop = 0;
            if (stat_ev && !reg_wdata[2]) m_cnt = 0;
            else if (last) m_cnt = (m_cnt + 1) % 256;
            if (push_ev && old_size == 64) m_ovf = 1;
            else if (stat_ev && !reg_wdata[3]) m_ovf = 0;
            if (push_ev && old_size < 64) mq.push_back(reg_wdata);
            if (reg_wr && reg_addr == 3'd1) begin
                m_len8 = reg_wdata[0]; m_pen = reg_wdata[1]; m_podd = reg_wdata[2];
                m_two = reg_wdata[3]; m_lie = reg_wdata[4]; m_sie = reg_wdata[5];
                m_sen = reg_wdata[6];
                if (reg_wdata[7]) mq.delete();
            end
            if (reg_wr && reg_addr == 3'd2) m_trig = int'(reg_wdata[5:0]);
            if (reg_wr && reg_addr == 3'd3) m_limit = int'(reg_wdata);
        end
    end

    task automatic cmp1(string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual %0d expected %0d at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (running) begin
            cmp1("txd", int'(txd), (mf.size() > 0) ? int'(mf[0]) : 1);
            cmp1("fifo_level", int'(fifo_level), mq.size());
            cmp1("flag_low", int'(flag_low), int'(m_low));
            cmp1("flag_end", int'(flag_end), int'(m_end));
            cmp1("flag_stop", int'(flag_stop), int'(m_stop));
            cmp1("flag_ovf", int'(flag_ovf), int'(m_ovf));
            cmp1("irq", int'(irq), int'((m_low && m_lie) || (m_stop && m_sie)));
        end
    end

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic push_burst(input int n, input int seed);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'd0;
        for (int i = 0; i < n; i++) begin
            reg_wdata = 8'((seed + i * 37) ^ (i << 2));
            @(negedge clk);
        end
        reg_wr = 1'b0;
    endtask

    task automatic wait_drain();
        for (int k = 0; k < 20000; k++) begin
            @(negedge clk);
            if (mq.size() == 0 && mf.size() == 0) break;
        end
        repeat (2 * DIV) @(negedge clk);
    endtask

    initial begin
        #(8 * 190000);
        n_bad++;
        $display("FAIL watchdog actual hung expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        cur_req = "R10";
        cmp1("reset txd", int'(txd), 1);
        cmp1("reset level", int'(fifo_level), 0);
        cmp1("reset end", int'(flag_end), 1);
        cmp1("reset low", int'(flag_low), 1);
        cmp1("reset stop", int'(flag_stop), 0);
        cmp1("reset ovf", int'(flag_ovf), 0);
        cmp1("reset irq", int'(irq), 0);
        rst_n = 1'b1;
        @(negedge clk);
        running = 1;

        // R3 R4 R5: 8 data, no parity, one stop, back to back frames
        cur_req = "R4";
        push_burst(3, 8'h5A);
        wait_drain();
        cur_req = "R5";
        wr_reg(3'd4, 8'hFD);
        repeat (20) @(negedge clk);

        // R3: 7 data, even parity, two stops
        cur_req = "R3";
        wr_reg(3'd1, 8'h0A);
        push_burst(2, 8'hC3);
        wait_drain();
        // R3: 8 data, odd parity, one stop
        wr_reg(3'd1, 8'h07);
        push_burst(3, 8'h81);
        wait_drain();

        // R1 R2: overflow by fast burst
        cur_req = "R2";
        wr_reg(3'd1, 8'h01);
        push_burst(70, 8'h11);
        repeat (5) @(negedge clk);
        cur_req = "R9";
        wr_reg(3'd1, 8'h81);
        repeat (10) @(negedge clk);
        cur_req = "R2";
        wr_reg(3'd4, 8'h07);
        wait_drain();

        // R1: level tracking on a moderate fill
        cur_req = "R1";
        push_burst(20, 8'h2F);
        wait_drain();

        // R6 R8: low-water level with interrupt
        cur_req = "R6";
        wr_reg(3'd2, 8'd4);
        wr_reg(3'd1, 8'h11);
        push_burst(10, 8'h47);
        wr_reg(3'd4, 8'hFE);
        repeat (150) @(negedge clk);
        cur_req = "R8";
        wr_reg(3'd4, 8'hFE);
        wait_drain();

        // R7: frame-count halt and resume
        cur_req = "R7";
        wr_reg(3'd2, 8'd0);
        wr_reg(3'd4, 8'hFB);
        wr_reg(3'd3, 8'd3);
        wr_reg(3'd1, 8'h61);
        push_burst(6, 8'h93);
        repeat (400) @(negedge clk);
        cmp1("halt level", int'(fifo_level), 3);
        cmp1("halt flag", int'(flag_stop), 1);
        wr_reg(3'd4, 8'hFB);
        repeat (400) @(negedge clk);
        cmp1("second halt flag", int'(flag_stop), 1);
        cur_req = "R8";
        wr_reg(3'd1, 8'h01);
        wr_reg(3'd4, 8'hFB);
        wait_drain();

        running = 0;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule